// File: doc/BRIEF.md
# Ten-Channel Chained DMA Controller

This block moves 16-bit words between addresses on a shared bus, using ten channels. Each channel holds its own source pointer, destination pointer, remaining-transfer counter, two pointer-step flags and a start mode. A channel starts work on a software pulse, on a level request from a peripheral, or on the end of a transfer made by another channel that it names. One channel can therefore wake the next one, and channels form chains.

Each transfer is one read beat from the source followed by one write beat of the same word to the destination. Both beats use a valid/ready handshake on the master port. The block raises `m_valid` and holds `m_write`, `m_addr` and `m_wdata` unchanged until the slave accepts the beat with `m_ready`, so the slave may stall either beat for any number of cycles. Read data is taken from `m_rdata` in the cycle where the read beat is accepted. When the counter of a channel runs out, that channel turns itself off and pulses its interrupt line. Transfers between two peripherals, between two RAM locations, or between a peripheral and RAM all look alike at this port.

Top module: `dma_chain_ctrl`

## Requirements
- R1: A cycle with `cfg_we` high loads pointers, counter, mode, link and step flags into channel `cfg_ch`, clears its queued starts, and sets its `ch_en` bit to `cfg_en`.
- R2: A transfer is a read beat at the source pointer (`m_write`=0) followed by a write beat (`m_write`=1) of the word read, at the destination pointer. Each beat holds `m_valid`, `m_write` and `m_addr` steady until `m_ready` is seen, and `m_valid` is low for at least one cycle between transfers.
- R3: After each transfer, the source pointer steps by +1 when its step flag is 1 and stays the same when it is 0. The destination pointer follows the same rule with its own flag.
- R4: A counter loaded with N gives N+1 transfers. The counter drops by one after each transfer. A transfer made while the counter is zero turns the channel off (`ch_en` bit low).
- R5: At that point, the channel's `irq` bit is high for exactly one cycle. It is never high at any other time.
- R6: The start modes are encoded as 0 = software, 1 = peripheral, 2 = chained. In software mode, each `sw_trig` pulse queues one transfer. In peripheral mode, the channel asks for transfers for as long as its `per_req` bit is high, and makes none while it is low.
- R7: In chained mode, every transfer completed by the channel named in `cfg_link` queues one transfer on this channel. A completion that arrives while this channel is off is dropped.
- R8: When several channels ask at once, the lowest-numbered one is served first. A transfer that has started runs to the end of its write beat before any other channel is served.
- R9: After reset, `m_valid`, every `ch_en` bit and every `irq` bit are low.
- R10: A `sw_trig` pulse sent to a channel that is off causes no transfer and leaves the channel off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the configuration fields into channel `cfg_ch` |
| cfg_ch | input | 4 | Channel being configured |
| cfg_en | input | 1 | Enable value written to the channel |
| cfg_mode | input | 2 | Start mode: 0 software, 1 peripheral, 2 chained |
| cfg_link | input | 4 | Upstream channel for chained mode |
| cfg_src_inc | input | 1 | Source pointer steps +1 after each transfer |
| cfg_dst_inc | input | 1 | Destination pointer steps +1 after each transfer |
| cfg_src | input | 16 | Source pointer |
| cfg_dst | input | 16 | Destination pointer |
| cfg_cnt | input | 8 | Counter (N gives N+1 transfers) |
| sw_trig | input | 10 | One-cycle software start pulses, one bit per channel |
| per_req | input | 10 | Peripheral request levels, one bit per channel |
| ch_en | output | 10 | Channel enabled flags |
| irq | output | 10 | One-cycle end-of-count pulses |
| m_valid | output | 1 | Beat valid on the master port |
| m_write | output | 1 | 1 for a write beat, 0 for a read beat |
| m_addr | output | 16 | Beat address |
| m_wdata | output | 16 | Write data |
| m_ready | input | 1 | Slave accepts the current beat |
| m_rdata | input | 16 | Read data, sampled when a read beat is accepted |

## Verification
Some properties are checked on every clock cycle. These are:
- the stability of a stalled beat;
- the move from a read beat to a write beat carrying the word just read;
- the idle gap between transfers;
- that at most one channel is granted, and that it is the lowest-numbered one asking;
- that a pointer with its step flag at 0 stays fixed;
- that the counter running out turns the channel off and pulses its interrupt.

Other behaviour can only be shown by the bench scenarios, because it depends on a sequence of events. This covers the exact address and data order over a whole run of transfers, the N+1 transfer count, chained starts that follow each upstream completion, chained starts dropped by a disabled channel, peripheral requests that follow the level of their input, and a lower-numbered request waiting until a stalled transfer has finished.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    TRG_SW   = 2'd0,
    TRG_PER  = 2'd1,
    TRG_CASC = 2'd2
  } trig_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } eng_st_e;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_mode,
  input  logic [IW-1:0] cfg_link,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          sw_trig,
  input  logic          per_req,
  input  logic          casc_in,
  input  logic          gnt,
  input  logic          fin,
  output logic          req,
  output logic          en,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [IW-1:0] link,
  output logic          irq
);
  logic          en_q, sinc_q, dinc_q, pend_q, irq_q;
  trig_e         mode_q;
  logic [IW-1:0] link_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          trig, last;

  assign trig = en_q & (((mode_q == TRG_SW) & sw_trig) | ((mode_q == TRG_CASC) & casc_in));
  assign last = fin & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= TRG_SW;
      link_q <= '0;
      sinc_q <= 1'b0;
      dinc_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cfg_we) begin
        en_q   <= cfg_en;
        mode_q <= trig_e'(cfg_mode);
        link_q <= cfg_link;
        sinc_q <= cfg_src_inc;
        dinc_q <= cfg_dst_inc;
        src_q  <= cfg_src;
        dst_q  <= cfg_dst;
        cnt_q  <= cfg_cnt;
        pend_q <= 1'b0;
      end else begin
        if (fin) begin
          src_q <= src_q + {{(AW-1){1'b0}}, sinc_q};
          dst_q <= dst_q + {{(AW-1){1'b0}}, dinc_q};
          if (cnt_q == '0) begin
            en_q  <= 1'b0;
            irq_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        if (last) pend_q <= 1'b0;
        else      pend_q <= (pend_q & ~gnt) | trig;
      end
    end
  end

  assign req  = en_q & (pend_q | ((mode_q == TRG_PER) & per_req));
  assign en   = en_q;
  assign src  = src_q;
  assign dst  = dst_q;
  assign link = link_q;
  assign irq  = irq_q;

  AST_UNDERFLOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !cfg_we) |=> (!en_q && irq_q)); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(last)); // R5
  AST_SRC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !sinc_q && !cfg_we) |=> $stable(src_q)); // R3
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 10,
  parameter int IW  = 4
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] win_oh,
  output logic [IW-1:0]  win_idx,
  output logic           any
);
  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        win_oh  = '0;
        win_oh[i] = 1'b1;
        win_idx = IW'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_req,
  input  logic [IW-1:0] win_idx,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  output logic          take,
  output logic [IW-1:0] cur,
  output logic          fin,
  output logic          m_valid,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic          m_ready,
  input  logic [DW-1:0] m_rdata
);
  eng_st_e       st_q;
  logic [IW-1:0] cur_q;
  logic [DW-1:0] data_q;

  assign take = (st_q == ST_IDLE) & any_req;
  assign fin  = (st_q == ST_WR) & m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (any_req) begin
          cur_q <= win_idx;
          st_q  <= ST_RD;
        end
        ST_RD: if (m_ready) begin
          data_q <= m_rdata;
          st_q   <= ST_WR;
        end
        ST_WR: if (m_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cur     = cur_q;
  assign m_valid = (st_q != ST_IDLE);
  assign m_write = (st_q == ST_WR);
  assign m_addr  = (st_q == ST_RD) ? src_addr : (st_q == ST_WR) ? dst_addr : '0;
  assign m_wdata = (st_q == ST_WR) ? data_q : '0;

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_write) && $stable(m_addr))); // R2
  AST_RD_TO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_write && m_ready) |=> (m_valid && m_write && m_wdata == $past(m_rdata))); // R2
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_write && m_ready) |=> !m_valid); // R2
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl #(
  parameter int NCH = 10,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_ch,
  input  logic           cfg_en,
  input  logic [1:0]     cfg_mode,
  input  logic [IW-1:0]  cfg_link,
  input  logic           cfg_src_inc,
  input  logic           cfg_dst_inc,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [CW-1:0]  cfg_cnt,
  input  logic [NCH-1:0] sw_trig,
  input  logic [NCH-1:0] per_req,
  output logic [NCH-1:0] ch_en,
  output logic [NCH-1:0] irq,
  output logic           m_valid,
  output logic           m_write,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic           m_ready,
  input  logic [DW-1:0]  m_rdata
);
  logic [NCH-1:0] ch_req, win_oh, gnt_vec, fin_vec, casc_in, done_q;
  logic [IW-1:0]  win_idx, cur;
  logic           any, take, fin;
  logic [AW-1:0]  src_arr [NCH];
  logic [AW-1:0]  dst_arr [NCH];
  logic [IW-1:0]  link_arr [NCH];

  assign gnt_vec = take ? win_oh : '0;
  assign fin_vec = fin ? (NCH'(1) << cur) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= '0;
    else        done_q <= fin_vec;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign casc_in[g] = (link_arr[g] < IW'(NCH)) ? done_q[link_arr[g]] : 1'b0;

    dma_chan #(.AW(AW), .CW(CW), .IW(IW)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we && (cfg_ch == IW'(g))),
      .cfg_en     (cfg_en),
      .cfg_mode   (cfg_mode),
      .cfg_link   (cfg_link),
      .cfg_src_inc(cfg_src_inc),
      .cfg_dst_inc(cfg_dst_inc),
      .cfg_src    (cfg_src),
      .cfg_dst    (cfg_dst),
      .cfg_cnt    (cfg_cnt),
      .sw_trig    (sw_trig[g]),
      .per_req    (per_req[g]),
      .casc_in    (casc_in[g]),
      .gnt        (gnt_vec[g]),
      .fin        (fin_vec[g]),
      .req        (ch_req[g]),
      .en         (ch_en[g]),
      .src        (src_arr[g]),
      .dst        (dst_arr[g]),
      .link       (link_arr[g]),
      .irq        (irq[g])
    );
  end

  dma_arb #(.NCH(NCH), .IW(IW)) u_arb (
    .req    (ch_req),
    .win_oh (win_oh),
    .win_idx(win_idx),
    .any    (any)
  );

  dma_engine #(.AW(AW), .DW(DW), .IW(IW)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_req (any),
    .win_idx (win_idx),
    .src_addr(src_arr[cur]),
    .dst_addr(dst_arr[cur]),
    .take    (take),
    .cur     (cur),
    .fin     (fin),
    .m_valid (m_valid),
    .m_write (m_write),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .m_ready (m_ready),
    .m_rdata (m_rdata)
  );

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec)); // R8
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vec != '0) |-> (((gnt_vec - 1'b1) & ch_req) == '0)); // R8
endmodule

// File: tb/dma_chain_ctrl_tb.sv
module dma_chain_ctrl_tb;
  localparam int NCH = 10;

  typedef struct packed {
    logic [3:0]  ch;
    logic [15:0] src;
    logic [15:0] dst;
    logic [7:0]  cnt;
    logic        si;
    logic        di;
    logic [1:0]  stall;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{4'd0, 16'h1000, 16'h2000, 8'd3, 1'b1, 1'b1, 2'd0},
    '{4'd9, 16'h1100, 16'h2100, 8'd0, 1'b1, 1'b1, 2'd1},
    '{4'd4, 16'h1200, 16'h2200, 8'd2, 1'b0, 1'b1, 2'd2},
    '{4'd6, 16'h1300, 16'h2300, 8'd2, 1'b1, 1'b0, 2'd1},
    '{4'd2, 16'h1400, 16'h2400, 8'd4, 1'b1, 1'b1, 2'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0;
  logic [3:0] cfg_ch = '0, cfg_link = '0;
  logic [1:0] cfg_mode = '0;
  logic [15:0] cfg_src = '0, cfg_dst = '0;
  logic [7:0] cfg_cnt = '0;
  logic [NCH-1:0] sw_trig = '0, per_req = '0;
  logic [NCH-1:0] ch_en, irq;
  logic m_valid, m_write, m_ready = 1'b0;
  logic [15:0] m_addr, m_wdata, m_rdata;

  int checks = 0, fails = 0;
  int hold = 0, stall = 0, cyc = 0;
  logic [15:0] wa [256];
  logic [15:0] wd [256];
  int wn = 0;
  int irq_cnt [NCH];

  always #2.5 clk = ~clk;

  dma_chain_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_en(cfg_en),
    .cfg_mode(cfg_mode), .cfg_link(cfg_link), .cfg_src_inc(cfg_src_inc),
    .cfg_dst_inc(cfg_dst_inc), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .sw_trig(sw_trig), .per_req(per_req), .ch_en(ch_en), .irq(irq),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata)
  );

  assign m_rdata = m_addr ^ 16'hA5C3;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    m_ready <= (hold == 0) && ((stall == 0) || ((cyc % (stall + 1)) == 0));
  end

  initial for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;

  always @(negedge clk) begin
    if (m_valid && m_ready && m_write) begin
      wa[wn % 256] = m_addr;
      wd[wn % 256] = m_wdata;
      wn = wn + 1;
    end
    for (int i = 0; i < NCH; i++) if (irq[i]) irq_cnt[i] = irq_cnt[i] + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic config_ch(input int ch, input bit en, input int mode, input int link,
                           input bit si, input bit di, input int src, input int dst, input int cnt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_en = en; cfg_mode = 2'(mode); cfg_link = 4'(link);
    cfg_src_inc = si; cfg_dst_inc = di; cfg_src = 16'(src); cfg_dst = 16'(dst); cfg_cnt = 8'(cnt);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_sw(input logic [NCH-1:0] mask);
    @(negedge clk);
    sw_trig = mask;
    @(negedge clk);
    sw_trig = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int ch, input int prev);
    for (int t = 0; t < 3000; t++) begin
      if (irq_cnt[ch] != prev) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    finish_run();
  end

  initial begin
    int base, prev, n;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R9 reset state
    chk(m_valid == 1'b0, "R9", m_valid, 0);
    chk(ch_en == '0, "R9", ch_en, 0);
    chk(irq == '0, "R9", irq, 0);

    // vector table: software-started runs of N+1 transfers
    foreach (VECS[v]) begin
      stall = VECS[v].stall;
      config_ch(VECS[v].ch, 1'b1, 0, 0, VECS[v].si, VECS[v].di, VECS[v].src, VECS[v].dst, VECS[v].cnt);
      chk(ch_en[VECS[v].ch] == 1'b1, "R1", ch_en[VECS[v].ch], 1);
      base = wn;
      prev = irq_cnt[VECS[v].ch];
      for (int k = 0; k <= int'(VECS[v].cnt); k++) begin
        pulse_sw(NCH'(1) << VECS[v].ch);
        idle(12);
      end
      wait_irq(VECS[v].ch, prev);
      idle(5);
      chk((wn - base) == int'(VECS[v].cnt) + 1, "R4", wn - base, int'(VECS[v].cnt) + 1);
      for (int k = 0; k <= int'(VECS[v].cnt); k++) begin
        logic [15:0] ea, es;
        ea = VECS[v].dst + (VECS[v].di ? 16'(k) : 16'd0);
        es = VECS[v].src + (VECS[v].si ? 16'(k) : 16'd0);
        chk(wa[(base + k) % 256] == ea, "R3", wa[(base + k) % 256], ea);
        chk(wd[(base + k) % 256] == (es ^ 16'hA5C3), "R2", wd[(base + k) % 256], es ^ 16'hA5C3);
      end
      chk(irq_cnt[VECS[v].ch] == prev + 1, "R5", irq_cnt[VECS[v].ch], prev + 1);
      chk(ch_en[VECS[v].ch] == 1'b0, "R4", ch_en[VECS[v].ch], 0);
    end
    stall = 0;

    // R8: simultaneous requests, lowest number first
    config_ch(5, 1'b1, 0, 0, 1'b1, 1'b1, 16'h1500, 16'h2500, 0);
    config_ch(2, 1'b1, 0, 0, 1'b1, 1'b1, 16'h1520, 16'h2520, 0);
    base = wn;
    pulse_sw(10'b0000100100);
    idle(30);
    chk(wa[base % 256] == 16'h2520, "R8", wa[base % 256], 16'h2520);
    chk(wa[(base + 1) % 256] == 16'h2500, "R8", wa[(base + 1) % 256], 16'h2500);

    // R8: a started transfer is not interrupted by a lower-numbered request
    config_ch(5, 1'b1, 0, 0, 1'b1, 1'b1, 16'h1540, 16'h3500, 0);
    config_ch(0, 1'b1, 0, 0, 1'b1, 1'b1, 16'h1560, 16'h3000, 0);
    hold = 1;
    idle(2);
    base = wn;
    pulse_sw(10'b0000100000);
    idle(3);
    pulse_sw(10'b0000000001);
    idle(2);
    hold = 0;
    idle(30);
    chk(wa[base % 256] == 16'h3500, "R8", wa[base % 256], 16'h3500);
    chk(wa[(base + 1) % 256] == 16'h3000, "R8", wa[(base + 1) % 256], 16'h3000);

    // R7: chained channel follows each upstream completion
    config_ch(3, 1'b1, 2, 1, 1'b1, 1'b1, 16'h1700, 16'h2700, 1);
    config_ch(1, 1'b1, 0, 0, 1'b1, 1'b1, 16'h1600, 16'h2600, 1);
    base = wn;
    prev = irq_cnt[3];
    pulse_sw(10'b0000000010);
    idle(15);
    pulse_sw(10'b0000000010);
    idle(40);
    n = 0;
    for (int k = base; k < wn; k++) if (wa[k % 256][15:8] == 8'h27) n++;
    chk(n == 2, "R7", n, 2);
    chk(irq_cnt[3] == prev + 1, "R7", irq_cnt[3], prev + 1);
    chk(ch_en[3] == 1'b0, "R7", ch_en[3], 0);

    // R7: completion dropped when chained channel is off
    config_ch(4, 1'b0, 2, 6, 1'b1, 1'b1, 16'h1800, 16'h2800, 0);
    config_ch(6, 1'b1, 0, 0, 1'b1, 1'b1, 16'h1900, 16'h2900, 0);
    base = wn;
    pulse_sw(10'b0001000000);
    idle(30);
    n = 0;
    for (int k = base; k < wn; k++) if (wa[k % 256][15:8] == 8'h28) n++;
    chk(n == 0, "R7", n, 0);
    chk(wn - base == 1, "R7", wn - base, 1);
    chk(ch_en[4] == 1'b0, "R7", ch_en[4], 0);

    // R6: peripheral level request
    config_ch(7, 1'b1, 1, 0, 1'b1, 1'b1, 16'h1A00, 16'h2A00, 2);
    base = wn;
    idle(20);
    chk(wn == base, "R6", wn - base, 0);
    prev = irq_cnt[7];
    per_req[7] = 1'b1;
    wait_irq(7, prev);
    idle(3);
    per_req[7] = 1'b0;
    idle(10);
    chk(wn - base == 3, "R6", wn - base, 3);
    chk(wa[(base + 2) % 256] == 16'h2A02, "R6", wa[(base + 2) % 256], 16'h2A02);

    // R10: software pulse to a disabled channel
    config_ch(8, 1'b0, 0, 0, 1'b1, 1'b1, 16'h1B00, 16'h2B00, 0);
    base = wn;
    pulse_sw(10'b0100000000);
    idle(20);
    chk(wn == base, "R10", wn - base, 0);
    chk(ch_en[8] == 1'b0, "R10", ch_en[8], 0);
    chk(m_valid == 1'b0, "R10", m_valid, 0);

    finish_run();
  end
endmodule